// File: doc/BRIEF.md
# Offset-Based Tick Register Unit

This block presents an architectural tick register to a processor core. The core advances a free-running count elsewhere, once per cycle or per retired instruction. The block never loads that count. It stores a 63-bit signed offset instead. A read returns the count plus the offset with the two lowest bits forced to zero. Bit 63 of a read is a separately stored trap-control flag. A write picks a new offset so that the next read returns the written value. The underlying count is never disturbed.

Three register selects address this one value: a user tick, a system tick and a privileged tick. Each compare unit holds a plain compare register. It raises a one-cycle interrupt pulse when the visible tick value first equals its compare value, unless the compare's top bit disables it. The access port is a plain strobed register port. It has no back-pressure: every read and every write is taken in the cycle it is strobed. Read data appears one cycle after the read strobe.

Top module: `tick_reg_unit`

## Requirements
- R1: Selects 0, 1 and 2 name the same tick value. A write through any of them is seen by a read through any other.
- R2: A tick read returns bits 62:2 of (count_in + offset) mod 2^63, with bits 1:0 reading zero. The data appears on rd_data with rd_vld high in the cycle after rd_en.
- R3: Bit 63 of a tick read is the stored trap-control flag, not a count bit.
- R4: A tick write sets offset = wr_data[62:0] - count_in, modulo 2^63, and sets the flag to wr_data[63]. If count_in is unchanged, the next read returns wr_data with bits 1:0 cleared, even when the subtraction wraps.
- R5: Reset state: flag = 1, offset = 0, every compare register = 0x8000_0000_0000_0000 (disabled), rd_vld = 0 and cmp_irq = 0.
- R6: Compare register i sits at select 3+i. With the default of two compare units, selects 3 and 4 read back all 64 written bits.
- R7: cmp_irq[i] is high for exactly one cycle. The pulse comes in the cycle after the first cycle in which tick bits 62:0 equal compare bits 62:0 while compare bit 63 is 0. It does not repeat while the equality holds.
- R8: A compare register with bit 63 set never raises its interrupt.
- R9: A read and a write in the same cycle return the value from before the write.
- R10: Selects above the last compare unit (5 to 7 by default) read as zero. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_in | input | 63 | Free-running count from the core |
| acc_sel | input | 3 | Register select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data, valid when rd_vld is high |
| rd_vld | output | 1 | Read data valid, one cycle after rd_en |
| cmp_irq | output | 2 | Compare-match interrupt pulses, one per compare unit |

## Verification
The bench builds the block with its defaults: 64-bit data, two zeroed low bits and two compare units. This leaves three selects unmapped, so the unmapped path can be exercised. The count is driven directly by the bench, so values just below 2^63 are within reach. With those values the wrapping offset subtraction and addition are exercised within a few cycles. Because the grain is two bits, a steadily advancing count holds one visible value for four cycles. This shows that a compare interrupt fires once and does not re-fire while the equality holds.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int SEL_W    = 3;
  localparam int CMP_BASE = 3;

  localparam logic [SEL_W-1:0] SEL_USR_TICK  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_SYS_TICK  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_PRIV_TICK = 3'd2;

  function automatic logic is_tick_sel(input logic [SEL_W-1:0] s);
    return (s == SEL_USR_TICK) || (s == SEL_SYS_TICK) || (s == SEL_PRIV_TICK);
  endfunction
endpackage

// File: rtl/tick_offset_core.sv
module tick_offset_core #(
  parameter int DATA_W = 64,
  parameter int GRAIN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-2:0] count_in,
  input  logic              wr_tick,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] vis_o
);
  localparam int VW = DATA_W - 1;

  logic [VW-1:0] off_q;
  logic          flag_q;
  logic [VW-1:0] sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      flag_q <= 1'b1;
    end else if (wr_tick) begin
      off_q  <= wr_data[VW-1:0] - count_in;
      flag_q <= wr_data[DATA_W-1];
    end
  end

  assign sum   = count_in + off_q;
  assign vis_o = {flag_q, sum[VW-1:GRAIN], {GRAIN{1'b0}}};

  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_tick |=> ($stable(off_q) && $stable(flag_q))); // R10
  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tick |=> ((count_in != $past(count_in)) ||
                 (vis_o[DATA_W-1:GRAIN] == $past(wr_data[DATA_W-1:GRAIN])))); // R4
endmodule

// File: rtl/tick_cmp_unit.sv
module tick_cmp_unit #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-2:0] vis_i,
  output logic [DATA_W-1:0] cmp_o,
  output logic              irq_o
);
  localparam int VW = DATA_W - 1;

  logic [DATA_W-1:0] cmp_q;
  logic              hit_now;
  logic              hit_prev;

  assign hit_now = !cmp_q[DATA_W-1] && (vis_i == cmp_q[VW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q    <= {1'b1, {VW{1'b0}}};
      hit_prev <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      if (wr_en) cmp_q <= wr_data;
      hit_prev <= hit_now;
      irq_o    <= hit_now && !hit_prev;
    end
  end

  assign cmp_o = cmp_q;

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o); // R7
  AST_IRQ_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(vis_i) == $past(cmp_q[VW-1:0]))); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !$past(cmp_q[DATA_W-1])); // R8
endmodule

// File: rtl/tick_read_port.sv
module tick_read_port
  import tick_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int GRAIN   = 2,
  parameter int NUM_CMP = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [SEL_W-1:0]          rd_sel,
  input  logic [DATA_W-1:0]         vis_i,
  input  logic [NUM_CMP*DATA_W-1:0] cmp_i,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      rd_vld
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (is_tick_sel(rd_sel)) rd_next = vis_i;
    for (int i = 0; i < NUM_CMP; i++) begin
      if (rd_sel == SEL_W'(CMP_BASE + i)) rd_next = cmp_i[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_data <= rd_next;
    end
  end

  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_vld); // R2
  AST_RD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && is_tick_sel($past(rd_sel))) |-> (rd_data[GRAIN-1:0] == '0)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && (int'($past(rd_sel)) >= CMP_BASE + NUM_CMP)) |-> (rd_data == '0)); // R10
endmodule

// File: rtl/tick_reg_unit.sv
module tick_reg_unit
  import tick_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int GRAIN   = 2,
  parameter int NUM_CMP = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-2:0]  count_in,
  input  logic [SEL_W-1:0]   acc_sel,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_vld,
  output logic [NUM_CMP-1:0] cmp_irq
);
  localparam int VW = DATA_W - 1;

  logic                      wr_tick;
  logic [DATA_W-1:0]         vis;
  logic [NUM_CMP*DATA_W-1:0] cmp_flat;

  assign wr_tick = wr_en && is_tick_sel(acc_sel);

  tick_offset_core #(.DATA_W(DATA_W), .GRAIN(GRAIN)) u_core (
    .clk(clk), .rst_n(rst_n), .count_in(count_in),
    .wr_tick(wr_tick), .wr_data(wr_data), .vis_o(vis)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(CMP_BASE + i);
    logic wr_me;
    assign wr_me = wr_en && (acc_sel == MY_SEL);
    tick_cmp_unit #(.DATA_W(DATA_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_me), .wr_data(wr_data),
      .vis_i(vis[VW-1:0]), .cmp_o(cmp_flat[i*DATA_W +: DATA_W]),
      .irq_o(cmp_irq[i])
    );
  end

  tick_read_port #(.DATA_W(DATA_W), .GRAIN(GRAIN), .NUM_CMP(NUM_CMP)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(acc_sel),
    .vis_i(vis), .cmp_i(cmp_flat), .rd_data(rd_data), .rd_vld(rd_vld)
  );

  AST_TICK_FLAG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && is_tick_sel($past(acc_sel)) && $past(rd_vld) &&
     is_tick_sel($past(acc_sel, 2)) && !$past(wr_en) && !$past(wr_en, 2))
    |-> (rd_data[DATA_W-1] == $past(rd_data[DATA_W-1]))); // R3
endmodule

// File: tb/tick_reg_unit_bench.sv
module tick_reg_unit_bench;
  localparam int DW = 64;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-2:0] count_in = '0;
  logic [2:0]    acc_sel = '0;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_vld;
  logic [NC-1:0] cmp_irq;

  always #4 clk = ~clk;

  tick_reg_unit u_tick_reg_unit (
    .clk(clk), .rst_n(rst_n), .count_in(count_in), .acc_sel(acc_sel),
    .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .rd_vld(rd_vld), .cmp_irq(cmp_irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  int pulses[NC];

  logic [62:0] m_off = '0;
  logic        m_flag = 1'b1;
  logic [63:0] m_cmp[NC];
  logic        m_prev[NC];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_vis(input logic [62:0] c);
    logic [62:0] s;
    s = c + m_off;
    return {m_flag, s[62:2], 2'b00};
  endfunction

  function automatic logic [63:0] exp_read(input logic [2:0] s, input logic [62:0] c);
    if (s <= 3'd2) return exp_vis(c);
    if (s == 3'd3) return m_cmp[0];
    if (s == 3'd4) return m_cmp[1];
    return '0;
  endfunction

  task automatic cyc(input logic [2:0] s, input bit rd, input bit wr,
                     input logic [63:0] wd, input logic [62:0] c, input string req);
    logic [63:0] er;
    logic [63:0] v;
    logic [NC-1:0] ei;
    @(negedge clk);
    acc_sel = s; rd_en = rd; wr_en = wr; wr_data = wd; count_in = c;
    er = exp_read(s, c);
    v = exp_vis(c);
    for (int i = 0; i < NC; i++) begin
      logic hit;
      hit = !m_cmp[i][63] && (v[62:0] == m_cmp[i][62:0]);
      ei[i] = hit && !m_prev[i];
      m_prev[i] = hit;
    end
    if (wr) begin
      if (s <= 3'd2) begin
        m_off = wd[62:0] - c;
        m_flag = wd[63];
      end else if (s == 3'd3) m_cmp[0] = wd;
      else if (s == 3'd4) m_cmp[1] = wd;
    end
    @(posedge clk);
    #1;
    chk({req, " rd_vld (R2)"}, {63'd0, rd_vld}, {63'd0, rd});
    if (rd) chk(req, rd_data, er);
    chk("R7 cmp_irq", {62'd0, cmp_irq}, {62'd0, ei});
    for (int i = 0; i < NC; i++) if (cmp_irq[i]) pulses[i]++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [62:0] c;
    logic [63:0] vtest;
    void'($urandom(32'd7));
    for (int i = 0; i < NC; i++) begin
      m_cmp[i] = 64'h8000_0000_0000_0000;
      m_prev[i] = 1'b0;
      pulses[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R5 rd_vld", {63'd0, rd_vld}, 64'd0);
    chk("R5 cmp_irq", {62'd0, cmp_irq}, 64'd0);

    cyc(3'd0, 1, 0, '0, 63'd1234, "R5 tick after reset");
    cyc(3'd3, 1, 0, '0, 63'd1235, "R5 cmp0 after reset");
    cyc(3'd4, 1, 0, '0, 63'd1236, "R5 cmp1 after reset");

    vtest = 64'h0123_4567_89AB_CDEF;
    cyc(3'd0, 0, 1, vtest, 63'd1000, "R4 write tick");
    cyc(3'd1, 1, 0, '0, 63'd1000, "R1 R4 read via system select");
    cyc(3'd2, 1, 0, '0, 63'd1000, "R1 R3 read via privileged select");
    cyc(3'd0, 1, 0, '0, 63'd1009, "R2 count advanced");

    cyc(3'd1, 1, 1, 64'hFFFF_0000_0000_1233, 63'd1010, "R9 same-cycle read old");
    cyc(3'd0, 1, 0, '0, 63'd1010, "R9 then new value R3");

    c = 63'h7FFF_FFFF_FFFF_FFF0;
    cyc(3'd2, 0, 1, 64'h8000_0000_0000_0010, c, "R4 wrap write");
    cyc(3'd0, 1, 0, '0, c, "R4 wrap readback");
    cyc(3'd0, 1, 0, '0, c + 63'h20, "R4 wrap after count wrap");

    cyc(3'd6, 0, 1, 64'hDEAD_BEEF_DEAD_BEEF, c + 63'h21, "R10 unmapped write");
    cyc(3'd5, 1, 0, '0, c + 63'h21, "R10 unmapped read zero");
    cyc(3'd7, 1, 0, '0, c + 63'h21, "R10 unmapped read zero 7");
    cyc(3'd0, 1, 0, '0, c + 63'h21, "R10 tick unchanged");

    cyc(3'd3, 1, 1, 64'h0000_0000_0000_0008, 63'd500, "R6 cmp0 write/read old");
    cyc(3'd3, 1, 0, '0, 63'd500, "R6 cmp0 readback");
    cyc(3'd4, 0, 1, 64'h8000_0000_0000_0008, 63'd500, "R8 disabled cmp1");
    cyc(3'd4, 1, 0, '0, 63'd500, "R6 cmp1 readback");
    cyc(3'd0, 0, 1, 64'd0, 63'd500, "R7 zero tick");
    pulses[0] = 0; pulses[1] = 0;
    for (int k = 1; k <= 20; k++) cyc(3'd0, 0, 0, '0, 63'(500 + k), "R7 run");
    chk("R7 single pulse cmp0", 64'(pulses[0]), 64'd1);
    chk("R8 no pulse cmp1", 64'(pulses[1]), 64'd0);

    c = 63'd77;
    for (int k = 0; k < 600; k++) begin
      logic [2:0] s;
      logic [63:0] wd;
      s = 3'($urandom % 8);
      wd = {$urandom, $urandom};
      if ($urandom % 4 == 0) wd[62:32] = '0;
      c = c + 63'($urandom % 3);
      cyc(s, bit'($urandom % 2), bit'($urandom % 3 == 0), wd, c, "R1 random access");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule